// File: doc/BRIEF.md
# Row-Column 8x8 Inverse DCT

This block turns an 8x8 block of frequency coefficients back into an 8x8 block of spatial samples. It uses the separable two-dimensional inverse cosine transform. One 8-point inverse transform unit is built from an even/odd butterfly factorization. That unit is shared in time: it first runs over the eight coefficient rows, then over the eight columns of the intermediate result. A register-based transpose store sits between the two halves, so the row results can be read back column by column.

A host writes the 64 signed coefficients one at a time into the coefficient store and then pulses `start`. The block spends one clock on each 1-D pass, sixteen passes in all, and then pulses `done`. After that the 64 samples can be read in any order through a combinational read port. Each sample is rounded to nearest and saturated to the signed 9-bit range. The block does not cover inverse quantisation or inverse scan order.

Top module: `idct8x8_rc`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every address of the sample read port returns 0.
- R2: While `busy` is 0, a cycle with `coef_we` high stores `coef_data` at `coef_addr`. The address is row-major: address = 8*v + u, where v is the vertical frequency and u is the horizontal frequency.
- R3: After `done`, the sample at address 8*y + x is within 1 of clip(1/4 · Σv Σu Cu Cv F(v,u) cos((2x+1)uπ/16) cos((2y+1)vπ/16)). Here Ck = 1/√2 for k = 0 and Ck = 1 otherwise.
- R4: Samples whose exact value lies outside -256..255 read back as -256 or 255.
- R5: A `start` pulse seen while idle raises `busy` on the next cycle. `done` rises exactly 16 clock edges after the edge that accepted `start` (8 row passes and 8 column passes).
- R6: `done` is high for exactly one cycle, and `busy` is low whenever `done` is high.
- R7: A `start` pulse while `busy` is high is ignored. The run keeps its timing, and no second `done` follows.
- R8: Coefficient writes while `busy` is high are ignored. The stored block is unchanged, both for the current run and for a later run started without reloading.
- R9: Results stay readable, unchanged and in any order, until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 6 | Coefficient address, row-major |
| coef_data | input | 12 | Signed coefficient value |
| start | input | 1 | Launches a transform when idle |
| busy | output | 1 | High during the 16 transform passes |
| done | output | 1 | One-cycle pulse when all samples are valid |
| pix_addr | input | 6 | Sample read address, row-major (8*y + x) |
| pix_data | output | 9 | Signed sample at `pix_addr` |

## Verification
The bench builds the block with its defaults: 12-bit coefficients, 9-bit samples and three fraction bits kept between the passes. At this size the bench sweeps every one of the 64 single-coefficient basis blocks and compares each sample with a double-precision evaluation of the cosine sum. The same sweep therefore covers every row and column path through the shared unit and the transpose store. Blocks of random coefficients and full-scale blocks then drive the rounding and both saturation limits. The timing checks cover a `start` pulse and a coefficient write landing in the middle of a run.

// File: rtl/idct_pkg.sv
`timescale 1ns/1ps
package idct_pkg;
    // block edge length; the butterfly below is written for eight points
    localparam int BLK   = 8;
    // fraction bits of the cosine constants
    localparam int COS_W = 12;
    // round(2^COS_W * cos(k*pi/16) / 2), k = 1..7; k = 4 also serves the zero-frequency term
    localparam int KC1 = 2009;
    localparam int KC2 = 1892;
    localparam int KC3 = 1703;
    localparam int KC4 = 1448;
    localparam int KC5 = 1138;
    localparam int KC6 = 784;
    localparam int KC7 = 400;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ROW  = 2'd1,
        PH_COL  = 2'd2
    } phase_e;
endpackage

// File: rtl/idct_1d_unit.sv
`timescale 1ns/1ps
module idct_1d_unit #(
    parameter int DW  = 18,
    parameter int ACW = 34
) (
    input  logic [idct_pkg::BLK-1:0][DW-1:0]  vec_i,
    output logic [idct_pkg::BLK-1:0][ACW-1:0] res_o
);
    localparam int N = idct_pkg::BLK;
    localparam int H = N / 2;

    localparam logic signed [ACW-1:0] C1 = ACW'(idct_pkg::KC1);
    localparam logic signed [ACW-1:0] C2 = ACW'(idct_pkg::KC2);
    localparam logic signed [ACW-1:0] C3 = ACW'(idct_pkg::KC3);
    localparam logic signed [ACW-1:0] C4 = ACW'(idct_pkg::KC4);
    localparam logic signed [ACW-1:0] C5 = ACW'(idct_pkg::KC5);
    localparam logic signed [ACW-1:0] C6 = ACW'(idct_pkg::KC6);
    localparam logic signed [ACW-1:0] C7 = ACW'(idct_pkg::KC7);

    logic signed [ACW-1:0] f [N];
    logic signed [ACW-1:0] ev [H];
    logic signed [ACW-1:0] od [H];
    logic signed [ACW-1:0] dc_sum, dc_dif;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_ext
            assign f[g] = {{(ACW-DW){vec_i[g][DW-1]}}, vec_i[g]};
        end
    endgenerate

    always_comb begin
        dc_sum = C4 * (f[0] + f[4]);
        dc_dif = C4 * (f[0] - f[4]);
        // even half: inputs 0, 2, 4, 6
        ev[0] = dc_sum + C2 * f[2] + C6 * f[6];
        ev[1] = dc_dif + C6 * f[2] - C2 * f[6];
        ev[2] = dc_dif - C6 * f[2] + C2 * f[6];
        ev[3] = dc_sum - C2 * f[2] - C6 * f[6];
        // odd half: inputs 1, 3, 5, 7
        od[0] = C1 * f[1] + C3 * f[3] + C5 * f[5] + C7 * f[7];
        od[1] = C3 * f[1] - C7 * f[3] - C1 * f[5] - C5 * f[7];
        od[2] = C5 * f[1] - C1 * f[3] + C7 * f[5] + C3 * f[7];
        od[3] = C7 * f[1] - C5 * f[3] + C3 * f[5] - C1 * f[7];
        for (int k = 0; k < H; k++) begin
            res_o[k]       = ev[k] + od[k];
            res_o[N-1-k]   = ev[k] - od[k];
        end
    end
endmodule

// File: rtl/idct_coef_store.sv
`timescale 1ns/1ps
module idct_coef_store #(
    parameter int IN_W = 12
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                lock_i,
    input  logic                                we_i,
    input  logic [$clog2(idct_pkg::BLK*idct_pkg::BLK)-1:0] addr_i,
    input  logic [IN_W-1:0]                     data_i,
    input  logic [$clog2(idct_pkg::BLK)-1:0]    row_sel_i,
    output logic [idct_pkg::BLK-1:0][IN_W-1:0]  row_o
);
    localparam int N  = idct_pkg::BLK;
    localparam int NN = N * N;
    localparam int LN = $clog2(N);

    logic [NN-1:0][IN_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we_i && !lock_i) mem_d[addr_i] = data_i;
        for (int k = 0; k < N; k++) row_o[k] = mem_q[{row_sel_i, LN'(k)}];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    // R8
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> $stable(mem_q));
endmodule

// File: rtl/idct_tpose_buf.sv
`timescale 1ns/1ps
module idct_tpose_buf #(
    parameter int W = 18
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we_i,
    input  logic [$clog2(idct_pkg::BLK)-1:0]  row_sel_i,
    input  logic [idct_pkg::BLK-1:0][W-1:0]   row_i,
    input  logic [$clog2(idct_pkg::BLK)-1:0]  col_sel_i,
    output logic [idct_pkg::BLK-1:0][W-1:0]   col_o
);
    localparam int N  = idct_pkg::BLK;
    localparam int NN = N * N;
    localparam int LN = $clog2(N);

    logic [NN-1:0][W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            for (int k = 0; k < N; k++) mem_d[{row_sel_i, LN'(k)}] = row_i[k];
        end
        for (int k = 0; k < N; k++) col_o[k] = mem_q[{LN'(k), col_sel_i}];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end
endmodule

// File: rtl/idct8x8_rc.sv
`timescale 1ns/1ps
module idct8x8_rc #(
    parameter int IN_W   = 12,
    parameter int OUT_W  = 9,
    parameter int FRAC_W = 3
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   coef_we,
    input  logic [$clog2(idct_pkg::BLK*idct_pkg::BLK)-1:0] coef_addr,
    input  logic [IN_W-1:0]                        coef_data,
    input  logic                                   start,
    output logic                                   busy,
    output logic                                   done,
    input  logic [$clog2(idct_pkg::BLK*idct_pkg::BLK)-1:0] pix_addr,
    output logic [OUT_W-1:0]                       pix_data
);
    import idct_pkg::*;

    localparam int N     = BLK;
    localparam int NN    = N * N;
    localparam int LN    = $clog2(N);
    localparam int TW    = IN_W + FRAC_W + 3;
    localparam int ACW   = TW + COS_W + 4;
    localparam int RSH   = COS_W - FRAC_W;
    localparam int CSH   = COS_W + FRAC_W;
    localparam int RCW   = $clog2(2 * N + 1);

    localparam logic signed [ACW-1:0] RBIAS = ACW'(2 ** (RSH - 1));
    localparam logic signed [ACW-1:0] CBIAS = ACW'(2 ** (CSH - 1));
    localparam logic signed [ACW-1:0] OMAX  = ACW'(2 ** (OUT_W - 1) - 1);
    localparam logic signed [ACW-1:0] OMIN  = ACW'(-(2 ** (OUT_W - 1)));

    typedef struct packed {
        phase_e                   phase;
        logic [LN-1:0]            idx;
        logic                     done;
        logic [NN-1:0][OUT_W-1:0] omem;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [N-1:0][IN_W-1:0] coef_row;
    logic [N-1:0][TW-1:0]   col_vec;
    logic [N-1:0][TW-1:0]   unit_in;
    logic [N-1:0][ACW-1:0]  unit_out;
    logic [N-1:0][TW-1:0]   row_res;
    logic [N-1:0][OUT_W-1:0] pix;
    logic signed [ACW-1:0]  crnd [N];
    logic                   row_we;

    assign busy     = (st_q.phase != PH_IDLE);
    assign done     = st_q.done;
    assign pix_data = st_q.omem[pix_addr];
    assign row_we   = (st_q.phase == PH_ROW);

    idct_coef_store #(.IN_W(IN_W)) u_coef (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_i    (busy),
        .we_i      (coef_we),
        .addr_i    (coef_addr),
        .data_i    (coef_data),
        .row_sel_i (st_q.idx),
        .row_o     (coef_row)
    );

    idct_tpose_buf #(.W(TW)) u_tpose (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (row_we),
        .row_sel_i (st_q.idx),
        .row_i     (row_res),
        .col_sel_i (st_q.idx),
        .col_o     (col_vec)
    );

    idct_1d_unit #(.DW(TW), .ACW(ACW)) u_unit (
        .vec_i (unit_in),
        .res_o (unit_out)
    );

    // operand select, rounding and clipping around the shared unit
    always_comb begin
        for (int k = 0; k < N; k++) begin
            if (st_q.phase == PH_ROW)
                unit_in[k] = {{(TW-IN_W){coef_row[k][IN_W-1]}}, coef_row[k]};
            else
                unit_in[k] = col_vec[k];
            row_res[k] = TW'((signed'(unit_out[k]) + RBIAS) >>> RSH);
            crnd[k]    = (signed'(unit_out[k]) + CBIAS) >>> CSH;
            if (crnd[k] > OMAX)      pix[k] = OUT_W'(OMAX);
            else if (crnd[k] < OMIN) pix[k] = OUT_W'(OMIN);
            else                     pix[k] = OUT_W'(crnd[k]);
        end
    end

    // sequencing: 8 row passes, then 8 column passes
    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_ROW;
                    st_d.idx   = '0;
                end
            end
            PH_ROW: begin
                st_d.idx = st_q.idx + 1'b1;
                if (st_q.idx == LN'(N - 1)) st_d.phase = PH_COL;
            end
            PH_COL: begin
                for (int k = 0; k < N; k++) st_d.omem[{LN'(k), st_q.idx}] = pix[k];
                st_d.idx = st_q.idx + 1'b1;
                if (st_q.idx == LN'(N - 1)) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // cycles since the accepted start, for the latency check only
    logic [RCW-1:0] run_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                run_cnt_q <= '0;
        else if (!busy && start)   run_cnt_q <= '0;
        else if (busy)             run_cnt_q <= run_cnt_q + RCW'(1);
    end

    // R5
    start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R5
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt_q == RCW'(2 * N)));
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R7
    relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);
endmodule

// File: tb/idct8x8_rc_tb.sv
`timescale 1ns/1ps
module idct8x8_rc_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       coef_we = 1'b0;
    logic [5:0] coef_addr = '0;
    logic [11:0] coef_data = '0;
    logic       start = 1'b0;
    logic       busy, done;
    logic [5:0] pix_addr = '0;
    logic [8:0] pix_data;

    int vectors = 0;
    int miscompares = 0;
    int coef [64];
    real refv [64];

    always #2 clk = ~clk;

    idct8x8_rc u_dut (
        .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_addr(coef_addr),
        .coef_data(coef_data), .start(start), .busy(busy), .done(done),
        .pix_addr(pix_addr), .pix_data(pix_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic compute_ref();
        real pi = 3.14159265358979;
        for (int y = 0; y < 8; y++) begin
            for (int x = 0; x < 8; x++) begin
                real s = 0.0;
                for (int v = 0; v < 8; v++) begin
                    for (int u = 0; u < 8; u++) begin
                        real cu = (u == 0) ? 0.70710678118655 : 1.0;
                        real cv = (v == 0) ? 0.70710678118655 : 1.0;
                        s = s + cu * cv * coef[v*8+u]
                              * $cos((2*x+1) * u * pi / 16.0)
                              * $cos((2*y+1) * v * pi / 16.0);
                    end
                end
                s = s / 4.0;
                if (s > 255.0) s = 255.0;
                if (s < -256.0) s = -256.0;
                refv[y*8+x] = s;
            end
        end
    endtask

    task automatic load_block();
        for (int a = 0; a < 64; a++) begin
            @(negedge clk);
            coef_we = 1'b1; coef_addr = 6'(a); coef_data = 12'(coef[a]);
        end
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic check_block(input string req, input bit reverse);
        for (int i = 0; i < 64; i++) begin
            int a = reverse ? 63 - i : i;
            int act;
            real d;
            pix_addr = 6'(a);
            #1;
            act = int'($signed(pix_data));
            d = act - refv[a];
            vectors++;
            if (d > 1.0 || d < -1.0) begin
                miscompares++;
                $display("FAIL %s addr %0d: actual %0d expected %.3f", req, a, act, refv[a]);
            end
        end
    endtask

    // R5 R6 (and R7/R8 when poking mid-run)
    task automatic run_block(input bit poke_start, input bit poke_wr);
        int n = 0;
        bit seen = 1'b0;
        @(negedge clk) start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        chk(busy == 1'b1, "R5 busy after start", int'(busy), 1);
        while (!seen && n < 40) begin
            @(posedge clk); #1;
            n++;
            start = 1'b0; coef_we = 1'b0;
            if (done) seen = 1'b1;
            else if (n == 5) begin
                if (poke_start) start = 1'b1;
                if (poke_wr) begin coef_we = 1'b1; coef_addr = 6'd0; coef_data = 12'd999; end
            end
        end
        chk(seen && n == 16, "R5 done latency", n, 16);
        chk(busy == 1'b0, "R6 busy low with done", int'(busy), 0);
        @(posedge clk); #1;
        chk(done == 1'b0, "R6 done single cycle", int'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        for (int a = 0; a < 64; a++) begin
            pix_addr = 6'(a); #1;
            chk(pix_data == '0, "R1 sample", int'($signed(pix_data)), 0);
        end
        @(negedge clk) rst_n = 1'b1;

        // R2 R3: sweep of all 64 single-coefficient basis blocks
        for (int p = 0; p < 64; p++) begin
            for (int a = 0; a < 64; a++) coef[a] = 0;
            coef[p] = (p % 2 == 0) ? (300 + 7*p) : -(300 + 7*p);
            compute_ref();
            load_block();
            run_block(1'b0, 1'b0);
            check_block("R2 R3 basis", 1'b0);
        end

        // R3 random dense blocks
        for (int b = 0; b < 8; b++) begin
            for (int a = 0; a < 64; a++) coef[a] = int'($urandom_range(160)) - 80;
            coef[0] = int'($urandom_range(1600)) - 800;
            compute_ref();
            load_block();
            run_block(1'b0, 1'b0);
            check_block("R3 random", 1'b0);
        end

        // R4 saturation: high, low, and both sides in one block
        for (int t = 0; t < 3; t++) begin
            for (int a = 0; a < 64; a++) coef[a] = 0;
            if (t == 0) coef[0] = 2047;
            if (t == 1) begin coef[0] = -2048; coef[8] = -2047; end
            if (t == 2) begin coef[1] = 2047; coef[8] = 900; end
            compute_ref();
            load_block();
            run_block(1'b0, 1'b0);
            check_block("R4 clip", 1'b0);
        end

        // R7 start while busy is ignored
        for (int a = 0; a < 64; a++) coef[a] = 0;
        coef[0] = 640; coef[9] = -500; coef[18] = 300;
        compute_ref();
        load_block();
        run_block(1'b1, 1'b0);
        begin
            bit quiet = 1'b1;
            repeat (30) begin
                @(posedge clk); #1;
                if (busy || done) quiet = 1'b0;
            end
            chk(quiet, "R7 no second run", int'(!quiet), 0);
        end
        check_block("R7 result", 1'b0);

        // R8 write during busy ignored, now and on a rerun without reload
        run_block(1'b0, 1'b1);
        check_block("R8 same run", 1'b0);
        run_block(1'b0, 1'b0);
        check_block("R8 rerun", 1'b0);

        // R9 results held and readable in any order
        repeat (50) @(posedge clk);
        check_block("R9 hold reverse", 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule